// File: doc/BRIEF.md
# Serial Result Master Transmitter

This block sends a finished conversion word out over a three-wire serial link whose clock it generates itself. The serial clock is the system clock divided by an even parameter, and a sync strobe marks the span in which the serial data is valid. A receiving device can therefore take each bit on either clock edge. The block watches a busy flag from the converter. A read-timing select decides when a frame is sent. In one setting the freshly finished word is sent as soon as busy drops. In the other, the word from the previous conversion is sent while the next conversion runs.

The block only transmits while both the serial-mode select and the internal-clock select are high. The clock and sync outputs can each be inverted, and they rest at their inactive level between frames. In the read-after-conversion setting, the busy indication the block drives outward stays high until the last bit has gone out. A frame already running is never disturbed by a new conversion. It finishes with the word it loaded at its start.

Top module: `serial_result_tx`

## Requirements
- R1: During reset and after it, with both inversion inputs low and no conversion, sclk, sdata, sync and busy_out are all low.
- R2: Each frame has exactly WORD_W rising edges of the normalised serial clock (pin XOR its inversion input) while sync is active. The data captured on those rising edges is the frame word, most significant bit first.
- R3: The data captured on the WORD_W falling edges inside the frame equals the same word. sdata never changes in the same cycle as the serial clock.
- R4: Rising serial-clock edges within a frame are CLK_DIV cycles apart. Sync is active for WORD_W*CLK_DIV + CLK_DIV/4 cycles.
- R5: With read_during = 0, a frame starts (sync active) 2 cycles after busy_in falls. It carries result_in as sampled at the first clock edge that sees busy_in low.
- R6: With read_during = 1, a frame starts 2 cycles after busy_in rises. It carries the word captured at the end of the previous conversion, which is zero after reset.
- R7: busy_out follows busy_in delayed by 2 cycles. When a read_during = 0 frame is running, busy_out instead stays high and falls in the same cycle that sync goes inactive.
- R8: sclk_inv = 1 inverts sclk and sync_inv = 1 inverts sync, so the idle levels of the pins equal the inversion inputs.
- R9: A conversion that starts and ends while a frame is running does not start a frame and does not alter the word being sent. Its result is still stored as the previous result for a later read_during = 1 frame.
- R10: Unless ser_mode and int_clk_mode are both high, no frame starts and sclk does not toggle. busy_out then only follows busy_in, but conversion results are still stored.
- R11: sdata is low whenever sync is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_mode | input | 1 | Serial output selected |
| int_clk_mode | input | 1 | Block generates the serial clock |
| busy_in | input | 1 | Conversion in progress |
| result_in | input | WORD_W | Conversion result, valid when busy_in falls |
| read_during | input | 1 | 0: send new word after conversion; 1: send previous word during conversion |
| sclk_inv | input | 1 | Invert the serial clock pin |
| sync_inv | input | 1 | Invert the sync pin |
| sclk | output | 1 | Generated serial clock |
| sdata | output | 1 | Serial data, MSB first |
| sync | output | 1 | Frame-valid strobe |
| busy_out | output | 1 | Busy, extended to frame end in read-after mode |

## Verification
A wrong bit counter or phase counter shows up within one frame as a rising-edge count other than WORD_W, an edge spacing other than CLK_DIV, or a sync span of the wrong length. The word captured on rising edges and the word captured on falling edges expose a shifter that moves at the wrong phase, because the data then changes on a clock edge in that same frame. Faults in the stored previous word or the mode decode only become visible one frame later, when a read_during = 1 frame sends the wrong word. A busy hold that clears early shows at the first read_during = 0 frame, as busy_out falling before sync.

// File: rtl/srt_pkg.sv
package srt_pkg;
   // read-timing select
   typedef enum logic {
      RD_AFTER  = 1'b0,
      RD_DURING = 1'b1
   } rd_mode_e;

   // the four pins driven by the block, before or after the output stage
   typedef struct packed {
      logic sclk;
      logic sync;
      logic sdata;
      logic busy;
   } srt_pins_t;
endpackage

// File: rtl/srt_ctrl.sv
module srt_ctrl
   import srt_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enable,
   input  logic         busy_in,
   input  logic [W-1:0] result_in,
   input  logic         read_during,
   input  logic         frame_active,
   input  logic         frame_done,
   output logic         start,
   output logic [W-1:0] load_word,
   output logic         busy_ext
);
   logic         busy_q;
   logic         hold_q;
   logic [W-1:0] last_word_q;
   logic         conv_start;
   logic         conv_end;
   rd_mode_e     mode;

   assign mode       = rd_mode_e'(read_during);
   assign conv_start = busy_in & ~busy_q;
   assign conv_end   = ~busy_in & busy_q;

   always_comb begin
      start = 1'b0;
      if (enable && !frame_active) begin
         unique case (mode)
            RD_AFTER:  start = conv_end;
            RD_DURING: start = conv_start;
         endcase
      end
   end

   assign load_word = (mode == RD_AFTER) ? result_in : last_word_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         hold_q      <= 1'b0;
         last_word_q <= '0;
      end else begin
         busy_q <= busy_in;
         if (conv_end) begin
            last_word_q <= result_in;
         end
         if (start && (mode == RD_AFTER)) begin
            hold_q <= 1'b1;
         end else if (frame_done) begin
            hold_q <= 1'b0;
         end
      end
   end

   assign busy_ext = busy_q | hold_q;
endmodule

// File: rtl/srt_timing.sv
module srt_timing #(
   parameter int W   = 16,
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active,
   output logic shift_en,
   output logic done,
   output logic sclk_raw
);
   localparam int PH_W  = (DIV > 1) ? $clog2(DIV) : 1;
   localparam int BIT_W = $clog2(W + 1);
   localparam int QTR   = DIV / 4;
   localparam int HALF  = DIV / 2;
   localparam logic [PH_W-1:0]  PH_LAST = PH_W'(DIV - 1);
   localparam logic [PH_W-1:0]  PH_MOVE = PH_W'(QTR - 1);
   localparam logic [PH_W-1:0]  PH_HIGH = PH_W'(HALF);
   localparam logic [BIT_W-1:0] BIT_END = BIT_W'(W);

   logic [PH_W-1:0]  ph_q;
   logic [BIT_W-1:0] bit_q;
   logic             act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         ph_q  <= '0;
         bit_q <= '0;
      end else if (start && !act_q) begin
         act_q <= 1'b1;
         ph_q  <= '0;
         bit_q <= '0;
      end else if (act_q) begin
         if (done) begin
            act_q <= 1'b0;
            ph_q  <= '0;
            bit_q <= '0;
         end else if (ph_q == PH_LAST) begin
            ph_q  <= '0;
            bit_q <= bit_q + 1'b1;
         end else begin
            ph_q <= ph_q + 1'b1;
         end
      end
   end

   assign active   = act_q;
   // data moves one quarter period into the low phase, away from both edges
   assign shift_en = act_q && (ph_q == PH_MOVE) && (bit_q != '0) && (bit_q < BIT_END);
   assign done     = act_q && (ph_q == PH_MOVE) && (bit_q == BIT_END);
   assign sclk_raw = act_q && (bit_q < BIT_END) && (ph_q >= PH_HIGH);
endmodule

// File: rtl/srt_shifter.sv
module srt_shifter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] word,
   output logic         msb
);
   logic [W-1:0] q;
   logic [W-1:0] d;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lsb
         assign d[i] = load ? word[i] : (shift ? 1'b0 : q[i]);
      end else begin : g_upper
         assign d[i] = load ? word[i] : (shift ? q[i-1] : q[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         q <= d;
      end
   end

   assign msb = q[W-1];
endmodule

// File: rtl/srt_outstage.sv
module srt_outstage
   import srt_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  srt_pins_t raw,
   input  logic      sclk_inv,
   input  logic      sync_inv,
   output srt_pins_t pins
);
   srt_pins_t shaped;

   always_comb begin
      shaped      = raw;
      shaped.sclk = raw.sclk ^ sclk_inv;
      shaped.sync = raw.sync ^ sync_inv;
   end

   if (REG_OUT) begin : g_reg
      srt_pins_t q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else begin
            q <= shaped;
         end
      end
      assign pins = q;
   end else begin : g_comb
      assign pins = shaped;
   end
endmodule

// File: rtl/serial_result_tx.sv
module serial_result_tx
   import srt_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int CLK_DIV = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_mode,
   input  logic              int_clk_mode,
   input  logic              busy_in,
   input  logic [WORD_W-1:0] result_in,
   input  logic              read_during,
   input  logic              sclk_inv,
   input  logic              sync_inv,
   output logic              sclk,
   output logic              sdata,
   output logic              sync,
   output logic              busy_out
);
   if ((CLK_DIV < 4) || ((CLK_DIV % 2) != 0)) begin : g_div_bad
      $error("serial_result_tx: CLK_DIV must be even and at least 4");
   end
   if (WORD_W < 2) begin : g_width_bad
      $error("serial_result_tx: WORD_W must be at least 2");
   end

   logic              enable;
   logic              start;
   logic              active;
   logic              shift_en;
   logic              done;
   logic              sclk_raw;
   logic              msb;
   logic              busy_ext;
   logic [WORD_W-1:0] load_word;
   srt_pins_t         raw;
   srt_pins_t         pins;

   assign enable = ser_mode & int_clk_mode;

   srt_ctrl #(.W(WORD_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .busy_in      (busy_in),
      .result_in    (result_in),
      .read_during  (read_during),
      .frame_active (active),
      .frame_done   (done),
      .start        (start),
      .load_word    (load_word),
      .busy_ext     (busy_ext)
   );

   srt_timing #(.W(WORD_W), .DIV(CLK_DIV)) u_timing (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .active   (active),
      .shift_en (shift_en),
      .done     (done),
      .sclk_raw (sclk_raw)
   );

   srt_shifter #(.W(WORD_W)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .shift (shift_en),
      .word  (load_word),
      .msb   (msb)
   );

   always_comb begin
      raw.sclk  = sclk_raw;
      raw.sync  = active;
      raw.sdata = active & msb;
      raw.busy  = busy_ext;
   end

   srt_outstage #(.REG_OUT(REG_OUT)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (raw),
      .sclk_inv (sclk_inv),
      .sync_inv (sync_inv),
      .pins     (pins)
   );

   assign sclk     = pins.sclk;
   assign sdata    = pins.sdata;
   assign sync     = pins.sync;
   assign busy_out = pins.busy;
endmodule

// File: rtl/srt_chk.sv
module srt_chk #(
   parameter int W   = 16,
   parameter int DIV = 4
) (
   input logic clk,
   input logic rst_n,
   input logic sclk_inv,
   input logic sync_inv,
   input logic sclk,
   input logic sdata,
   input logic sync
);
   localparam int SPAN = W * DIV + DIV / 4;
   localparam int CW   = $clog2(W + 2);

   logic          ci_q, si_q, sclk_n_q;
   logic          sclk_n, sync_n;
   logic [CW-1:0] rise_q;
   int unsigned   span_q;

   assign sclk_n = sclk ^ ci_q;
   assign sync_n = sync ^ si_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ci_q     <= 1'b0;
         si_q     <= 1'b0;
         sclk_n_q <= 1'b0;
         rise_q   <= '0;
         span_q   <= 0;
      end else begin
         ci_q     <= sclk_inv;
         si_q     <= sync_inv;
         sclk_n_q <= sclk_n;
         if (!sync_n) begin
            rise_q <= '0;
            span_q <= 0;
         end else begin
            span_q <= span_q + 1;
            if (sclk_n && !sclk_n_q) begin
               rise_q <= rise_q + 1'b1;
            end
         end
      end
   end

   // R2
   clk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_n != sclk_n_q) |-> (sync_n && $past(sync_n)));
   // R3
   data_edge_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_n != sclk_n_q) |-> $stable(sdata));
   // R11
   idle_data_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_n |-> !sdata);
   // R2
   rise_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_n) |-> (rise_q == CW'(W)));
   // R4
   sync_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_n |-> (span_q < SPAN));
endmodule

bind serial_result_tx srt_chk #(.W(WORD_W), .DIV(CLK_DIV)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sclk_inv (sclk_inv),
   .sync_inv (sync_inv),
   .sclk     (sclk),
   .sdata    (sdata),
   .sync     (sync)
);

// File: tb/sim_serial_result_tx.sv
module sim_serial_result_tx;
   localparam int W    = 16;
   localparam int DIV  = 4;
   localparam int SPAN = W * DIV + DIV / 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ser_mode = 1'b1, int_clk_mode = 1'b1;
   logic         busy_in = 1'b0, read_during = 1'b0;
   logic         sclk_inv = 1'b0, sync_inv = 1'b0;
   logic [W-1:0] result_in = '0;
   logic         sclk, sdata, sync, busy_out;
   logic [W-1:0] prev_word = '0;
   int           n_chk = 0, n_bad = 0;
   bit           finished = 1'b0;

   always #2.5 clk = ~clk;

   serial_result_tx #(.WORD_W(W), .CLK_DIV(DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .int_clk_mode(int_clk_mode),
      .busy_in(busy_in), .result_in(result_in), .read_during(read_during),
      .sclk_inv(sclk_inv), .sync_inv(sync_inv),
      .sclk(sclk), .sdata(sdata), .sync(sync), .busy_out(busy_out)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_start(input bit during, input int blen);
      return during ? 2 : blen + 2;
   endfunction

   function automatic logic [W-1:0] exp_word(input bit during, input logic [W-1:0] w);
      return during ? prev_word : w;
   endfunction

   task automatic set_pol(input bit ci, input bit si);
      @(negedge clk);
      sclk_inv = ci;
      sync_inv = si;
      repeat (3) @(negedge clk);
   endtask

   // one conversion: busy rises at sample 0, falls at sample blen; optional
   // second conversion rises at xa and falls at xa+6 with xword
   task automatic run_conv(input bit during, input logic [W-1:0] word,
                           input int blen, input int xa, input logic [W-1:0] xword);
      bit           en;
      bit           pcs, pss, pd, pb, cs, ss, d, b;
      int           s_rise, s_fall, b_fall, rises, falls, collide, gap_bad, idle_bad, last_rise;
      logic [W-1:0] cap_r, cap_f, want;
      int           lim;
      en  = ser_mode & int_clk_mode;
      want = exp_word(during, word);
      s_rise = -1; s_fall = -1; b_fall = -1; last_rise = -1;
      rises = 0; falls = 0; collide = 0; gap_bad = 0; idle_bad = 0;
      cap_r = '0; cap_f = '0;
      lim = blen + SPAN + 10;
      @(negedge clk);
      read_during = during;
      busy_in = 1'b1;
      pcs = sclk ^ sclk_inv; pss = sync ^ sync_inv; pd = sdata; pb = busy_out;
      for (int i = 1; i < lim; i++) begin
         @(negedge clk);
         cs = sclk ^ sclk_inv; ss = sync ^ sync_inv; d = sdata; b = busy_out;
         if (ss && !pss && s_rise < 0) s_rise = i;
         if (!ss && pss && s_fall < 0) s_fall = i;
         if (!b && pb && b_fall < 0) b_fall = i;
         if ((cs != pcs) && (d != pd)) collide++;
         if (cs && !pcs && ss) begin
            cap_r = {cap_r[W-2:0], d};
            rises++;
            if (last_rise >= 0 && (i - last_rise) != DIV) gap_bad++;
            last_rise = i;
         end
         if (!cs && pcs && ss) begin
            cap_f = {cap_f[W-2:0], d};
            falls++;
         end
         if (!ss && (d || cs)) idle_bad++;
         if (!en && (cs != pcs)) idle_bad++;
         if (i == blen) begin result_in = word; busy_in = 1'b0; end
         if (xa > 0 && i == xa) busy_in = 1'b1;
         if (xa > 0 && i == xa + 6) begin result_in = xword; busy_in = 1'b0; end
         pcs = cs; pss = ss; pd = d; pb = b;
      end
      if (en) begin
         check(s_rise == exp_start(during, blen), during ? "R6" : "R5", "frame start", s_rise, exp_start(during, blen));
         check(rises == W, "R2", "rising edges", rises, W);
         check(cap_r == want, during ? "R6" : "R2", "word on rising edges", cap_r, want);
         check(falls == W && cap_f == want, "R3", "word on falling edges", cap_f, want);
         check(collide == 0, "R3", "data moved on clock edge", collide, 0);
         check((s_fall - s_rise) == SPAN, "R4", "sync span", s_fall - s_rise, SPAN);
         check(gap_bad == 0, "R4", "edge spacing", gap_bad, 0);
         if (xa > 0) check(cap_r == want, "R9", "word kept across mid-frame conversion", cap_r, want);
         if (!during) check(b_fall == s_fall, "R7", "busy_out fall", b_fall, s_fall);
         else         check(b_fall == blen + 2, "R7", "busy_out fall", b_fall, blen + 2);
      end else begin
         check(s_rise < 0 && rises == 0, "R10", "frame while disabled", rises, 0);
         check(b_fall == blen + 2, "R10", "busy_out while disabled", b_fall, blen + 2);
      end
      check(idle_bad == 0, "R11", "idle data or clock activity", idle_bad, 0);
      check(sclk == sclk_inv && sync == sync_inv, "R8", "idle pin levels",
            {sclk, sync}, {sclk_inv, sync_inv});
      prev_word = (xa > 0) ? xword : word;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7321));
      repeat (4) @(negedge clk);
      // R1 during reset
      check({sclk, sdata, sync, busy_out} == 4'b0, "R1", "outputs in reset", {sclk, sdata, sync, busy_out}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check({sclk, sdata, sync, busy_out} == 4'b0, "R1", "outputs after reset", {sclk, sdata, sync, busy_out}, 0);

      // directed corners
      run_conv(1'b1, 16'h3C3C, 8, 0, '0);        // R6: previous word is zero
      run_conv(1'b0, 16'h8001, 5, 0, '0);        // R5
      run_conv(1'b1, 16'h1234, 10, 0, '0);       // R6 sends 8001
      run_conv(1'b1, 16'hFFFF, 60, 0, '0);       // R6 sends 1234, long busy
      run_conv(1'b0, 16'h0F0F, 6, 30, 16'h5A5A); // R9 mid-frame conversion
      run_conv(1'b1, 16'h0000, 12, 0, '0);       // R9 stored 5A5A goes out
      set_pol(1'b1, 1'b1);
      run_conv(1'b0, 16'hA5C3, 7, 0, '0);        // R8
      set_pol(1'b1, 1'b0);
      run_conv(1'b1, 16'h6E01, 9, 0, '0);        // R8 clock only
      set_pol(1'b0, 1'b0);
      @(negedge clk) ser_mode = 1'b0;
      run_conv(1'b0, 16'h7E11, 8, 0, '0);        // R10
      @(negedge clk) begin ser_mode = 1'b1; int_clk_mode = 1'b0; end
      run_conv(1'b1, 16'h2222, 8, 0, '0);        // R10
      @(negedge clk) int_clk_mode = 1'b1;
      run_conv(1'b1, 16'h4444, 8, 0, '0);        // R10: stored 2222 goes out

      // constrained random
      for (int k = 0; k < 40; k++) begin
         bit           rd, ci, si;
         int           blen;
         logic [W-1:0] w;
         rd = 1'($urandom_range(0, 1));
         ci = 1'($urandom_range(0, 1));
         si = 1'($urandom_range(0, 1));
         w  = W'($urandom());
         blen = rd ? int'($urandom_range(3, 60)) : int'($urandom_range(3, 40));
         if (ci != sclk_inv || si != sync_inv) set_pol(ci, si);
         run_conv(rd, w, blen, 0, '0);
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule